// File: doc/BRIEF.md
# Laser Transmitter Fault Supervisor

This block is the digital supervisor that sits beside the analog core of an optical transmitter driver. It receives comparator flags from the analog front end for four monitored nodes: the bias-current monitor, the monitor photodiode, the extinction-ratio reference and the bias output node. Each node has an over flag and an under flag. A per-node direction table decides which of the two flags is allowed to raise an alarm. The block also receives the transmitter shutdown pin and a fault-override pin. From these it drives the bias and modulation current enables and a latched, active-high fault flag.

After reset, every alarm is blanked for a fixed number of ticks. Each flag is synchronized and must stay asserted for a debounce interval before it counts. The first alarm that qualifies latches the fault and records its source in a one-hot status word. The fault can only be cleared by holding shutdown high for a minimum time and then releasing it. All timing runs on a tick from an internal prescaler.

At a 200 MHz clock, a 1 µs tick needs a prescaler of 200. A 25 ms blanking window then needs 25000 ticks, and a 5 µs clear hold needs 5 ticks. The defaults are smaller so that short simulations can exercise the block.

Top module: `lfs_supervisor`

## Requirements
- R1: While the synchronized shutdown input is high, `bias_en_o` and `mod_en_o` are both 0, no later than 3 clock cycles after the pin rises. From reset the shutdown synchronizer reads high, so both enables come out of reset at 0, as an undriven pin pulled high would give.
- R2: Once `fail_o` is 1, it stays 1 until the clear sequence of R3 completes. Further alarms, their removal and the override input do not change it.
- R3: The clear sequence is: the shutdown input stays high for at least `HOLD_TICKS` ticks, then goes low. This sets `fail_o` and `first_src_o` to 0. A shorter high pulse leaves the fault latched.
- R4: For `BLANK_TICKS` ticks after reset, every alarm is ignored. An alarm that is still qualified when the window ends sets `fail_o`.
- R5: The direction table is set by the parameters. With the defaults, the rules per node are:
  - node 0 (bias monitor) alarms on over only;
  - node 1 (photodiode) alarms on over and on under;
  - node 2 (extinction reference, short to supply) alarms on over only;
  - node 3 (bias node under-voltage) alarms on under only.

  A flag that the table disables never sets `fail_o`.
- R6: A flag must read high, after its two-flop synchronizer, for `DEB_TICKS` consecutive ticks before it qualifies. A shorter pulse has no effect.
- R7: While `fail_o` is 1 and the synchronized override is 0, both enables are 0. While the override is 1, the enables follow only the shutdown input, and `fail_o` stays 1.
- R8: A qualifying flag raises `fail_o` within `4 + (DEB_TICKS+1)*PRESCALE` cycles. The enables return to 1 within 3 cycles after shutdown falls, as long as no fault is blocking them.
- R9: `first_src_o` holds a one-hot code of the alarm that set the fault. Bit 2n is the over flag of node n, and bit 2n+1 is the under flag of node n. If several alarms qualify in the same cycle, the lowest bit index wins. Later alarms do not change the code. The code is all zero whenever `fail_o` is 0.
- R10: While shutdown is high, no new fault is latched.
- R11: If an alarm is still qualified when the clear sequence ends, the fault latches again on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shutdown_i | input | 1 | Transmitter shutdown. High turns the currents off. A high-then-low sequence clears a fault |
| fail_ovr_i | input | 1 | Keeps the currents on while a fault is latched |
| over_i | input | NODES | Per-node over-threshold comparator flags |
| under_i | input | NODES | Per-node under-threshold comparator flags |
| bias_en_o | output | 1 | Bias current enable |
| mod_en_o | output | 1 | Modulation current enable |
| fail_o | output | 1 | Latched fault flag, active high |
| first_src_o | output | 2*NODES | One-hot code of the alarm source that set the fault |

## Verification
The ports expose any fault in the internal state quickly:
- A blanking counter that ends early shows up as `fail_o` rising in the middle of the window.
- A wrong direction mask sets `fail_o` on a disabled flag within about twenty cycles.
- A debounce counter that does not reset on a dropped flag lets a short glitch latch a fault.
- A hold counter that does not restart lets a short shutdown pulse clear the fault a few cycles after its falling edge.

The bench times each fault against the latency bound. It checks the one-hot source code after simultaneous alarms. It also checks that the enables respond within three cycles to shutdown, fault and override.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    ST_BLANK = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2
  } lfs_state_e;

  // Position of a node's flag in the one-hot source word.
  function automatic int unsigned src_over_idx(input int unsigned node);
    return 2 * node;
  endfunction

  function automatic int unsigned src_under_idx(input int unsigned node);
    return 2 * node + 1;
  endfunction
endpackage

// File: rtl/lfs_prescaler.sv
module lfs_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && DIV > 1) |=> !tick_o); // R8
endmodule

// File: rtl/lfs_sync2.sv
module lfs_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lfs_debounce.sv
module lfs_debounce #(
  parameter int DEB_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic level_i,
  output logic qual_o
);
  localparam int CW = (DEB_TICKS < 1) ? 1 : $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] FULL = CW'(DEB_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (!level_i) cnt_q <= '0;
    else if (tick_i && (cnt_q != FULL)) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = level_i && (cnt_q == FULL);

  AST_DEB_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o && DEB_TICKS > 0) |-> $past(level_i)); // R6
endmodule

// File: rtl/lfs_fault_latch.sv
module lfs_fault_latch
  import lfs_pkg::*;
#(
  parameter int NSRC        = 8,
  parameter int BLANK_TICKS = 40,
  parameter int HOLD_TICKS  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            sd_i,
  input  logic [NSRC-1:0] alarm_i,
  output logic            fail_o,
  output logic [NSRC-1:0] first_o
);
  localparam int BW = (BLANK_TICKS < 1) ? 1 : $clog2(BLANK_TICKS + 1);
  localparam int HW = (HOLD_TICKS < 1) ? 1 : $clog2(HOLD_TICKS + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_TICKS);
  localparam logic [HW-1:0] HOLD_MAX  = HW'(HOLD_TICKS);

  lfs_state_e      state_q;
  logic [BW-1:0]   blank_q;
  logic [HW-1:0]   hold_q;
  logic [NSRC-1:0] first_q;
  logic [NSRC-1:0] pick;

  // Lowest index wins when several alarms qualify together.
  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (alarm_i[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BLANK;
      blank_q <= '0;
      hold_q  <= '0;
      first_q <= '0;
    end else begin
      case (state_q)
        ST_BLANK: begin
          if (blank_q == BLANK_END) state_q <= ST_RUN;
          else if (tick_i) blank_q <= blank_q + 1'b1;
        end
        ST_RUN: begin
          hold_q <= '0;
          if (!sd_i && (|alarm_i)) begin
            state_q <= ST_FAULT;
            first_q <= pick;
          end
        end
        ST_FAULT: begin
          if (sd_i) begin
            if (tick_i && (hold_q != HOLD_MAX)) hold_q <= hold_q + 1'b1;
          end else if (hold_q == HOLD_MAX) begin
            state_q <= ST_RUN;
            first_q <= '0;
            hold_q  <= '0;
          end else begin
            hold_q <= '0;
          end
        end
        default: state_q <= ST_BLANK;
      endcase
    end
  end

  assign fail_o  = (state_q == ST_FAULT);
  assign first_o = first_q;

  AST_BLANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLANK) |=> !fail_o); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && hold_q != HOLD_MAX) |=> fail_o); // R2
  AST_CLEAR_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_o) |-> (!$past(sd_i) && $past(sd_i, 2))); // R3
  AST_NO_LATCH_IN_SD: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_i && !fail_o) |=> !fail_o); // R10
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_o) && (fail_o || first_o == '0)); // R9
endmodule

// File: rtl/lfs_supervisor.sv
module lfs_supervisor
  import lfs_pkg::*;
#(
  parameter int              NODES       = 4,
  parameter logic [NODES-1:0] OVER_MASK  = 4'b0111,
  parameter logic [NODES-1:0] UNDER_MASK = 4'b1010,
  parameter int              PRESCALE    = 4,
  parameter int              DEB_TICKS   = 3,
  parameter int              BLANK_TICKS = 40,
  parameter int              HOLD_TICKS  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shutdown_i,
  input  logic               fail_ovr_i,
  input  logic [NODES-1:0]   over_i,
  input  logic [NODES-1:0]   under_i,
  output logic               bias_en_o,
  output logic               mod_en_o,
  output logic               fail_o,
  output logic [2*NODES-1:0] first_src_o
);
  localparam int NSRC = 2 * NODES;

  logic              tick;
  logic              sd_q, ovr_q;
  logic [NSRC-1:0]   alarm_vec;
  logic              fail;
  logic              en_d;
  logic              bias_en_q, mod_en_q;

  lfs_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  // Shutdown resets high: treated as asserted until the pin is seen low.
  lfs_sync2 #(.RST_VAL(1'b1)) u_sd_sync (
    .clk(clk), .rst_n(rst_n), .d_i(shutdown_i), .q_o(sd_q)
  );

  lfs_sync2 #(.RST_VAL(1'b0)) u_ovr_sync (
    .clk(clk), .rst_n(rst_n), .d_i(fail_ovr_i), .q_o(ovr_q)
  );

  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic ov_s, un_s, ov_qual, un_qual;

    lfs_sync2 #(.RST_VAL(1'b0)) u_ov_sync (
      .clk(clk), .rst_n(rst_n), .d_i(over_i[n]), .q_o(ov_s)
    );
    lfs_sync2 #(.RST_VAL(1'b0)) u_un_sync (
      .clk(clk), .rst_n(rst_n), .d_i(under_i[n]), .q_o(un_s)
    );
    lfs_debounce #(.DEB_TICKS(DEB_TICKS)) u_ov_deb (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .level_i(ov_s), .qual_o(ov_qual)
    );
    lfs_debounce #(.DEB_TICKS(DEB_TICKS)) u_un_deb (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .level_i(un_s), .qual_o(un_qual)
    );

    // Direction table: a disabled direction never reaches the latch.
    assign alarm_vec[src_over_idx(n)]  = ov_qual & OVER_MASK[n];
    assign alarm_vec[src_under_idx(n)] = un_qual & UNDER_MASK[n];
  end

  lfs_fault_latch #(
    .NSRC(NSRC), .BLANK_TICKS(BLANK_TICKS), .HOLD_TICKS(HOLD_TICKS)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sd_i(sd_q),
    .alarm_i(alarm_vec), .fail_o(fail), .first_o(first_src_o)
  );

  assign en_d = !sd_q && (!fail || ovr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_en_q <= 1'b0;
      mod_en_q  <= 1'b0;
    end else begin
      bias_en_q <= en_d;
      mod_en_q  <= en_d;
    end
  end

  assign bias_en_o = bias_en_q;
  assign mod_en_o  = mod_en_q;
  assign fail_o    = fail;

  AST_SD_CUTS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    sd_q |=> (!bias_en_o && !mod_en_o)); // R1
  AST_FAIL_CUTS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !ovr_q) |=> (!bias_en_o && !mod_en_o)); // R7
  AST_OVR_KEEPS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_q && ovr_q) |=> (bias_en_o && mod_en_o)); // R7
endmodule

// File: tb/tb_lfs_supervisor.sv
module tb_lfs_supervisor;
  localparam int NODES = 4;
  localparam int PRESC = 4;
  localparam int DEB   = 3;
  localparam int LAT   = 4 + (DEB + 1) * PRESC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shutdown_i = 1'b1;
  logic fail_ovr_i = 1'b0;
  logic [NODES-1:0] over_i = '0;
  logic [NODES-1:0] under_i = '0;
  logic bias_en_o, mod_en_o, fail_o;
  logic [2*NODES-1:0] first_src_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lfs_supervisor dut (
    .clk(clk), .rst_n(rst_n), .shutdown_i(shutdown_i), .fail_ovr_i(fail_ovr_i),
    .over_i(over_i), .under_i(under_i), .bias_en_o(bias_en_o),
    .mod_en_o(mod_en_o), .fail_o(fail_o), .first_src_o(first_src_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: act=%0d exp=<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2*NODES-1:0] src_bit(input int node, input bit under);
    return (2*NODES)'(1) << (2 * node + (under ? 1 : 0));
  endfunction

  task automatic do_clear();
    shutdown_i = 1'b1;
    wait_cyc(40);
    shutdown_i = 1'b0;
    wait_cyc(6);
  endtask

  task automatic t_reset_state();
    wait_cyc(2);
    chk("R1 reset fail", fail_o, 0);
    chk("R1 reset bias_en", bias_en_o, 0);
    chk("R1 reset mod_en", mod_en_o, 0);
    chk("R9 reset src", first_src_o, 0);
    shutdown_i = 1'b0;
    wait_cyc(4);
    chk("R8 release bias_en", bias_en_o, 1);
    chk("R8 release mod_en", mod_en_o, 1);
  endtask

  task automatic t_blanking();
    under_i[1] = 1'b1;
    wait_cyc(60);
    under_i[1] = 1'b0;
    wait_cyc(20);
    chk("R4 blank ignores", fail_o, 0);
    over_i[2] = 1'b1;
    wait_cyc(50);
    chk("R4 still blanked", fail_o, 0);
    wait_cyc(60);
    chk("R4 present at end", fail_o, 1);
    chk("R9 src node2 over", first_src_o, src_bit(2, 0));
    chk("R7 fail cuts bias", bias_en_o, 0);
    chk("R7 fail cuts mod", mod_en_o, 0);
    over_i[2] = 1'b0;
  endtask

  task automatic t_clear();
    shutdown_i = 1'b1;
    wait_cyc(8);
    chk("R1 sd cuts bias", bias_en_o, 0);
    chk("R1 sd cuts mod", mod_en_o, 0);
    shutdown_i = 1'b0;
    wait_cyc(6);
    chk("R3 short pulse keeps fail", fail_o, 1);
    chk("R2 fail sticky after flag drop", first_src_o, src_bit(2, 0));
    do_clear();
    chk("R3 clear fail", fail_o, 0);
    chk("R3 clear src", first_src_o, 0);
    chk("R8 enables back", bias_en_o, 1);
  endtask

  task automatic t_ignored();
    under_i[0] = 1'b1;
    wait_cyc(40);
    chk("R5 node0 under ignored", fail_o, 0);
    under_i[0] = 1'b0;
    under_i[2] = 1'b1;
    wait_cyc(40);
    chk("R5 node2 under ignored", fail_o, 0);
    under_i[2] = 1'b0;
    over_i[3] = 1'b1;
    wait_cyc(40);
    chk("R5 node3 over ignored", fail_o, 0);
    chk("R5 enables kept", mod_en_o, 1);
    over_i[3] = 1'b0;
    wait_cyc(5);
  endtask

  task automatic t_source(input int node, input bit under);
    int lat;
    lat = 0;
    if (under) under_i[node] = 1'b1; else over_i[node] = 1'b1;
    while (!fail_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R5 source latches", fail_o, 1);
    checks++;
    if (lat > LAT) begin
      errors++;
      $display("FAIL R8 latency: act=%0d exp<=%0d", lat, LAT);
    end
    chk("R9 source code", first_src_o, src_bit(node, under));
    under_i[node] = 1'b0;
    over_i[node] = 1'b0;
    do_clear();
    chk("R3 source cleared", fail_o, 0);
  endtask

  task automatic t_glitch();
    over_i[1] = 1'b1;
    wait_cyc(6);
    over_i[1] = 1'b0;
    wait_cyc(30);
    chk("R6 glitch ignored", fail_o, 0);
    over_i[1] = 1'b1;
    wait_cyc(30);
    chk("R6 steady flag latches", fail_o, 1);
    over_i[1] = 1'b0;
    do_clear();
  endtask

  task automatic t_priority();
    under_i[3] = 1'b1;
    over_i[1]  = 1'b1;
    wait_cyc(25);
    chk("R9 lowest index wins", first_src_o, src_bit(1, 0));
    over_i[0] = 1'b1;
    wait_cyc(25);
    chk("R9 first source kept", first_src_o, src_bit(1, 0));
    chk("R2 fail kept", fail_o, 1);
    under_i = '0;
    over_i  = '0;
    do_clear();
  endtask

  task automatic t_override();
    over_i[0] = 1'b1;
    wait_cyc(25);
    chk("R7 fail set", fail_o, 1);
    fail_ovr_i = 1'b1;
    wait_cyc(5);
    chk("R7 override bias on", bias_en_o, 1);
    chk("R7 override mod on", mod_en_o, 1);
    chk("R7 override fail shown", fail_o, 1);
    fail_ovr_i = 1'b0;
    wait_cyc(5);
    chk("R7 override off cuts", bias_en_o, 0);
    over_i[0] = 1'b0;
    do_clear();
  endtask

  task automatic t_sd_mask();
    shutdown_i = 1'b1;
    over_i[2] = 1'b1;
    wait_cyc(40);
    chk("R10 no latch in shutdown", fail_o, 0);
    over_i[2] = 1'b0;
    wait_cyc(10);
    shutdown_i = 1'b0;
    wait_cyc(6);
    chk("R10 no fail after release", fail_o, 0);
    chk("R10 enables on", bias_en_o, 1);
  endtask

  task automatic t_relatch();
    under_i[3] = 1'b1;
    wait_cyc(25);
    chk("R11 initial fail", fail_o, 1);
    do_clear();
    chk("R11 relatched", fail_o, 1);
    chk("R11 relatch src", first_src_o, src_bit(3, 1));
    under_i[3] = 1'b0;
    do_clear();
    chk("R11 final clear", fail_o, 0);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    t_reset_state();
    t_blanking();
    t_clear();
    t_ignored();
    t_source(0, 0);
    t_source(1, 0);
    t_source(1, 1);
    t_source(2, 0);
    t_source(3, 1);
    t_glitch();
    t_priority();
    t_override();
    t_sd_mask();
    t_relatch();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule